// File: doc/BRIEF.md
# Dual-register bidirectional bus transceiver

This block links two 8-bit buses, called A and B, in both directions. Each direction has its own storage register with its own capture clock. The A-side register samples the A bus and the B-side register samples the B bus. Each direction also has a route select, which picks either the live value of the far bus or the stored register value. It also has a drive enable, which switches the block's output onto the opposite bus. The A-to-B enable is active high and the B-to-A enable is active low. With the A-to-B enable low and the B-to-A enable high, neither bus is driven.

Each bus pin group is modelled as three separate vectors, so a wrapper can resolve them into tri-state nets:
- a raw input value;
- a flag saying that some external agent is driving the bus;
- an output value with a matching vector of per-bit drive enables.

The block keeps a keeper register for each bus, clocked on a free-running core clock. Whenever nothing drives a bus, the bus takes the keeper value. Both registers capture the resolved bus value, which may be the block's own drive. This is how one bus value can be stored in both registers.

When both directions are enabled and both selects choose live data, the two buses are joined. Each side reinforces the other. The joined bus follows an external driver while one is present. Once every external driver releases, both buses keep their last value.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst_n_i` is low, both storage registers and both keepers are zero. Reset deassertion reaches each register only after two rising edges of that register's own clock. After that, stored-mode outputs and the joined-mode output with no external driver read 0x00.
- R2: On every rising edge of `clk_a_i`, the A storage register loads the resolved A bus value, and on every rising edge of `clk_b_i`, the B storage register loads the resolved B bus value. The select and enable inputs have no effect on capture.
- R3: The resolved value of a bus is chosen in this order:
  - the raw input, if its external-driver flag is 1;
  - otherwise the block's own output, if the block drives that bus;
  - otherwise the bus keeper.

  A keeper loads its bus on each `clk_i` edge while the bus has any driver, and holds otherwise.
- R4: `b_oe_o` is all ones when `en_ab_i` is 1 and all zeros when it is 0 (active high).
- R5: `a_oe_o` is all ones when `en_ba_n_i` is 0 and all zeros when it is 1 (active low).
- R6: With `en_ab_i`=0 and `en_ba_n_i`=1 (isolation), both drive-enable vectors are zero.
- R7: While B is driven and not joined, `sel_ab_i`=0 drives `b_out_o` with the resolved A bus value, and `sel_ab_i`=1 drives it with the A storage register.
- R8: While A is driven and not joined, `sel_ba_i`=0 drives `a_out_o` with the resolved B bus value, and `sel_ba_i`=1 drives it with the B storage register.
- R9: With both enables active and both selects 1, A carries stored B data and B carries stored A data at the same time.
- R10: If B is driven with live A data, a `clk_b_i` edge stores that A value in the B register. The mirror case stores the B value in the A register.
- R11: In joined mode (both enables active, both selects 0), both outputs follow `a_in_i` when `a_ext_i` is 1. Otherwise they follow `b_in_i` when `b_ext_i` is 1. Otherwise each output follows its own bus keeper.
- R12: After all external drivers release a joined bus, both buses keep the last driven value for as long as the mode stays unchanged. A capture edge taken in that state stores the kept value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running core clock for the bus keepers |
| clk_a_i | input | 1 | Capture clock of the A storage register |
| clk_b_i | input | 1 | Capture clock of the B storage register |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| en_ab_i | input | 1 | Drive enable toward B, active high |
| en_ba_n_i | input | 1 | Drive enable toward A, active low |
| sel_ab_i | input | 1 | B source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A source: 0 live B, 1 stored B |
| a_in_i | input | 8 | Raw A bus value from external agents |
| a_ext_i | input | 1 | An external agent drives the A bus |
| a_out_o | output | 8 | Value the block drives onto A |
| a_oe_o | output | 8 | Per-bit drive enable for A |
| b_in_i | input | 8 | Raw B bus value from external agents |
| b_ext_i | input | 1 | An external agent drives the B bus |
| b_out_o | output | 8 | Value the block drives onto B |
| b_oe_o | output | 8 | Per-bit drive enable for B |

## Verification
The routing is tried under every enable combination:
- Isolation, one-way drive in each direction, and exchange of the two stored values tell the two enable polarities apart.
- A/B data patterns that differ from the stored values show whether each select picks the live or the stored path.
- Mixed modes test whether a live path reads the block's own drive on the far bus rather than the raw pin. Here one side is stored and the other live, with no external driver.

Joined mode is driven in three ways: from A alone, from B alone, and from both at once, which exposes the priority. All drivers are then released, and the kept value is checked a number of core cycles later and captured into a register. Capture is tested with enables off and with both buses driven by the block, which shows that select and enable have no effect on storage.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned XCVR_DATA_W = 8;
  localparam int unsigned XCVR_SYNC_STAGES = 2;

  // Source chosen for one direction's output.
  typedef enum logic [1:0] {
    PATH_OFF    = 2'd0,
    PATH_LIVE   = 2'd1,
    PATH_STORED = 2'd2,
    PATH_JOINED = 2'd3
  } path_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/xcvr_reg.sv
module xcvr_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (ld_i) begin
      val_d = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign q_o = val_q;

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         en_ab_i,
  input  logic         en_ba_n_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_in_i,
  input  logic         a_ext_i,
  input  logic [W-1:0] b_in_i,
  input  logic         b_ext_i,
  input  logic [W-1:0] reg_a_i,
  input  logic [W-1:0] reg_b_i,
  input  logic [W-1:0] keep_a_i,
  input  logic [W-1:0] keep_b_i,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] b_out_o,
  output logic         drive_a_o,
  output logic         drive_b_o,
  output logic [W-1:0] a_bus_o,
  output logic [W-1:0] b_bus_o,
  output logic         joined_o
);

  logic  drive_a;
  logic  drive_b;
  logic  joined;
  path_e path_a;
  path_e path_b;

  // Bus values seen by a live path; the far side is never joined here.
  logic [W-1:0] a_far;
  logic [W-1:0] b_far;
  // Bus values when both sides reinforce each other.
  logic [W-1:0] pick_a;
  logic [W-1:0] pick_b;

  always_comb begin
    drive_b = en_ab_i;
    drive_a = ~en_ba_n_i;
    joined  = drive_a & drive_b & ~sel_ab_i & ~sel_ba_i;

    if (!drive_b)      path_b = PATH_OFF;
    else if (joined)   path_b = PATH_JOINED;
    else if (sel_ab_i) path_b = PATH_STORED;
    else               path_b = PATH_LIVE;

    if (!drive_a)      path_a = PATH_OFF;
    else if (joined)   path_a = PATH_JOINED;
    else if (sel_ba_i) path_a = PATH_STORED;
    else               path_a = PATH_LIVE;
  end

  always_comb begin
    if (a_ext_i)                  a_far = a_in_i;
    else if (drive_a && sel_ba_i) a_far = reg_b_i;
    else                          a_far = keep_a_i;

    if (b_ext_i)                  b_far = b_in_i;
    else if (drive_b && sel_ab_i) b_far = reg_a_i;
    else                          b_far = keep_b_i;

    if (a_ext_i)      pick_a = a_in_i;
    else if (b_ext_i) pick_a = b_in_i;
    else              pick_a = keep_a_i;

    if (a_ext_i)      pick_b = a_in_i;
    else if (b_ext_i) pick_b = b_in_i;
    else              pick_b = keep_b_i;
  end

  always_comb begin
    unique case (path_b)
      PATH_STORED: b_out_o = reg_a_i;
      PATH_LIVE:   b_out_o = a_far;
      PATH_JOINED: b_out_o = pick_b;
      default:     b_out_o = '0;
    endcase

    unique case (path_a)
      PATH_STORED: a_out_o = reg_b_i;
      PATH_LIVE:   a_out_o = b_far;
      PATH_JOINED: a_out_o = pick_a;
      default:     a_out_o = '0;
    endcase
  end

  always_comb begin
    if (a_ext_i)      a_bus_o = a_in_i;
    else if (drive_a) a_bus_o = a_out_o;
    else              a_bus_o = keep_a_i;

    if (b_ext_i)      b_bus_o = b_in_i;
    else if (drive_b) b_bus_o = b_out_o;
    else              b_bus_o = keep_b_i;
  end

  assign drive_a_o = drive_a;
  assign drive_b_o = drive_b;
  assign joined_o  = joined;

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = XCVR_DATA_W,
  parameter int unsigned STAGES = XCVR_SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_n_i,
  input  logic         en_ab_i,
  input  logic         en_ba_n_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_in_i,
  input  logic         a_ext_i,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_in_i,
  input  logic         b_ext_i,
  output logic [W-1:0] b_out_o,
  output logic [W-1:0] b_oe_o
);

  localparam int unsigned NUM_DOM  = 3;  // core, A capture, B capture
  localparam int unsigned NUM_SIDE = 2;  // 0 = A, 1 = B

  logic [NUM_DOM-1:0] dom_clk;
  logic [NUM_DOM-1:0] dom_rst_n;

  logic rst_core_n;
  logic rst_a_n;
  logic rst_b_n;

  logic [W-1:0] reg_a_q;
  logic [W-1:0] reg_b_q;
  logic [W-1:0] keep_a_q;
  logic [W-1:0] keep_b_q;
  logic [W-1:0] a_bus;
  logic [W-1:0] b_bus;
  logic         drive_a;
  logic         drive_b;
  logic         joined;

  logic [NUM_SIDE-1:0]        cap_clk;
  logic [NUM_SIDE-1:0]        cap_rst_n;
  logic [NUM_SIDE-1:0]        keep_ld;
  logic [NUM_SIDE-1:0][W-1:0] side_bus;
  logic [NUM_SIDE-1:0][W-1:0] side_reg;
  logic [NUM_SIDE-1:0][W-1:0] side_keep;

  assign dom_clk = {clk_b_i, clk_a_i, clk_i};

  genvar gd;
  generate
    for (gd = 0; gd < NUM_DOM; gd++) begin : g_rst
      xcvr_rst_sync #(.STAGES(STAGES)) u_sync (
        .clk_i   (dom_clk[gd]),
        .rst_n_i (rst_n_i),
        .rst_n_o (dom_rst_n[gd])
      );
    end
  endgenerate

  assign rst_core_n = dom_rst_n[0];
  assign rst_a_n    = dom_rst_n[1];
  assign rst_b_n    = dom_rst_n[2];

  assign cap_clk   = {clk_b_i, clk_a_i};
  assign cap_rst_n = {rst_b_n, rst_a_n};
  assign side_bus  = {b_bus, a_bus};
  // A keeper loads while its bus has any driver at all.
  assign keep_ld   = {b_ext_i | drive_b, a_ext_i | drive_a};

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SIDE; gs++) begin : g_side
      xcvr_reg #(.W(W)) u_store (
        .clk_i   (cap_clk[gs]),
        .rst_n_i (cap_rst_n[gs]),
        .ld_i    (1'b1),
        .d_i     (side_bus[gs]),
        .q_o     (side_reg[gs])
      );
      xcvr_reg #(.W(W)) u_keep (
        .clk_i   (clk_i),
        .rst_n_i (rst_core_n),
        .ld_i    (keep_ld[gs]),
        .d_i     (side_bus[gs]),
        .q_o     (side_keep[gs])
      );
    end
  endgenerate

  assign reg_a_q  = side_reg[0];
  assign reg_b_q  = side_reg[1];
  assign keep_a_q = side_keep[0];
  assign keep_b_q = side_keep[1];

  xcvr_route #(.W(W)) u_route (
    .en_ab_i   (en_ab_i),
    .en_ba_n_i (en_ba_n_i),
    .sel_ab_i  (sel_ab_i),
    .sel_ba_i  (sel_ba_i),
    .a_in_i    (a_in_i),
    .a_ext_i   (a_ext_i),
    .b_in_i    (b_in_i),
    .b_ext_i   (b_ext_i),
    .reg_a_i   (reg_a_q),
    .reg_b_i   (reg_b_q),
    .keep_a_i  (keep_a_q),
    .keep_b_i  (keep_b_q),
    .a_out_o   (a_out_o),
    .b_out_o   (b_out_o),
    .drive_a_o (drive_a),
    .drive_b_o (drive_b),
    .a_bus_o   (a_bus),
    .b_bus_o   (b_bus),
    .joined_o  (joined)
  );

  assign a_oe_o = {W{drive_a}};
  assign b_oe_o = {W{drive_b}};

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         clk_a_i,
  input logic         clk_b_i,
  input logic         rst_core_n,
  input logic         rst_a_n,
  input logic         rst_b_n,
  input logic         en_ab_i,
  input logic         en_ba_n_i,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_in_i,
  input logic         a_ext_i,
  input logic         b_ext_i,
  input logic [W-1:0] a_out_o,
  input logic [W-1:0] b_out_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_oe_o,
  input logic [W-1:0] reg_a_q,
  input logic [W-1:0] reg_b_q,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus
);

  logic idle_join;
  assign idle_join = en_ab_i && !en_ba_n_i && !sel_ab_i && !sel_ba_i
                     && !a_ext_i && !b_ext_i;

  assert_cap_a_R2: assert property (@(posedge clk_a_i) disable iff (!rst_a_n)
    rst_a_n |=> (reg_a_q == $past(a_bus)));

  assert_cap_b_R2: assert property (@(posedge clk_b_i) disable iff (!rst_b_n)
    rst_b_n |=> (reg_b_q == $past(b_bus)));

  assert_oe_b_R4: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (b_oe_o == '0) || (b_oe_o == '1));

  assert_oe_a_R5: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (a_oe_o == '0) || (a_oe_o == '1));

  assert_isolate_R6: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (!en_ab_i && en_ba_n_i) |-> (a_oe_o == '0 && b_oe_o == '0));

  assert_stored_b_R7: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (en_ab_i && sel_ab_i) |-> (b_out_o == reg_a_q));

  assert_stored_a_R8: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (!en_ba_n_i && sel_ba_i) |-> (a_out_o == reg_b_q));

  assert_join_a_R11: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (en_ab_i && !en_ba_n_i && !sel_ab_i && !sel_ba_i && a_ext_i)
      |-> (a_out_o == a_in_i && b_out_o == a_in_i));

  assert_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (idle_join && $past(idle_join)) |-> ($stable(a_out_o) && $stable(b_out_o)));

endmodule

bind dual_reg_xcvr xcvr_checker #(.W(W)) u_checker (
  .clk_i      (clk_i),
  .clk_a_i    (clk_a_i),
  .clk_b_i    (clk_b_i),
  .rst_core_n (rst_core_n),
  .rst_a_n    (rst_a_n),
  .rst_b_n    (rst_b_n),
  .en_ab_i    (en_ab_i),
  .en_ba_n_i  (en_ba_n_i),
  .sel_ab_i   (sel_ab_i),
  .sel_ba_i   (sel_ba_i),
  .a_in_i     (a_in_i),
  .a_ext_i    (a_ext_i),
  .b_ext_i    (b_ext_i),
  .a_out_o    (a_out_o),
  .b_out_o    (b_out_o),
  .a_oe_o     (a_oe_o),
  .b_oe_o     (b_oe_o),
  .reg_a_q    (reg_a_q),
  .reg_b_q    (reg_b_q),
  .a_bus      (a_bus),
  .b_bus      (b_bus)
);

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W          = 8;
  localparam int unsigned NUM_ROWS   = 11;
  localparam int unsigned WDOG_CYC   = 20000;

  typedef struct packed {
    logic         en_ab;
    logic         en_ba_n;
    logic         sel_ab;
    logic         sel_ba;
    logic         a_ext;
    logic         b_ext;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic         a_oe;
    logic [W-1:0] a_out;
    logic         b_oe;
    logic [W-1:0] b_out;
  } row_t;

  // Stored values during the table: A register 0x3C, B register 0xA5.
  localparam row_t ROWS [NUM_ROWS] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00}, // R6
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A}, // R4 R7 live
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 8'h00, 1'b1, 8'h3C}, // R7 stored
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hC3, 1'b1, 8'hC3, 1'b0, 8'h00}, // R5 R8 live
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hC3, 1'b1, 8'hA5, 1'b0, 8'h00}, // R8 stored
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b1, 8'h3C}, // R9
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h3C, 1'b1, 8'h3C}, // R3 R8
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA5, 1'b1, 8'hA5}, // R3 R7
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h96, 8'h00, 1'b1, 8'h96, 1'b1, 8'h96}, // R11 A
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h69, 1'b1, 8'h69, 1'b1, 8'h69}, // R11 B
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b1, 8'h0F, 1'b1, 8'h0F}  // R11 both
  };

  logic         clk_i;
  logic         clk_a_i;
  logic         clk_b_i;
  logic         rst_n_i;
  logic         en_ab_i;
  logic         en_ba_n_i;
  logic         sel_ab_i;
  logic         sel_ba_i;
  logic [W-1:0] a_in_i;
  logic         a_ext_i;
  logic [W-1:0] a_out_o;
  logic [W-1:0] a_oe_o;
  logic [W-1:0] b_in_i;
  logic         b_ext_i;
  logic [W-1:0] b_out_o;
  logic [W-1:0] b_oe_o;

  int unsigned n_checks;
  int unsigned n_errors;
  logic        done;

  dual_reg_xcvr #(.W(W)) dut_i (
    .clk_i     (clk_i),
    .clk_a_i   (clk_a_i),
    .clk_b_i   (clk_b_i),
    .rst_n_i   (rst_n_i),
    .en_ab_i   (en_ab_i),
    .en_ba_n_i (en_ba_n_i),
    .sel_ab_i  (sel_ab_i),
    .sel_ba_i  (sel_ba_i),
    .a_in_i    (a_in_i),
    .a_ext_i   (a_ext_i),
    .a_out_o   (a_out_o),
    .a_oe_o    (a_oe_o),
    .b_in_i    (b_in_i),
    .b_ext_i   (b_ext_i),
    .b_out_o   (b_out_o),
    .b_oe_o    (b_oe_o)
  );

  initial begin
    clk_i = 1'b0;
    forever #(CLK_PERIOD / 2) clk_i = ~clk_i;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic eab, input logic eban, input logic sab, input logic sba);
    en_ab_i   = eab;
    en_ba_n_i = eban;
    sel_ab_i  = sab;
    sel_ba_i  = sba;
  endtask

  task automatic set_ext(input logic ae, input logic [W-1:0] av,
                         input logic be, input logic [W-1:0] bv);
    a_ext_i = ae;
    a_in_i  = av;
    b_ext_i = be;
    b_in_i  = bv;
  endtask

  task automatic pulse_a();
    #1 clk_a_i = 1'b1;
    #1 clk_a_i = 1'b0;
    #1;
  endtask

  task automatic pulse_b();
    #1 clk_b_i = 1'b1;
    #1 clk_b_i = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    clk_a_i  = 1'b0;
    clk_b_i  = 1'b0;
    rst_n_i  = 1'b0;
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    set_ext(1'b0, '0, 1'b0, '0);
    repeat (3) step();
    rst_n_i = 1'b1;
    pulse_a();
    pulse_a();
    pulse_b();
    pulse_b();
    repeat (3) step();

    // R1: reset state of keepers and storage registers
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    step();
    #1;
    check("R1 keeper A", a_out_o, 8'h00);
    check("R1 keeper B", b_out_o, 8'h00);
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    #1;
    check("R1 stored B reg", a_out_o, 8'h00);
    check("R1 stored A reg", b_out_o, 8'h00);

    // Load A=0x3C and B=0xA5 while isolated
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    set_ext(1'b1, 8'h3C, 1'b1, 8'hA5);
    pulse_a();
    pulse_b();
    set_ext(1'b0, '0, 1'b0, '0);

    for (int i = 0; i < NUM_ROWS; i++) begin
      step();
      set_ctl(ROWS[i].en_ab, ROWS[i].en_ba_n, ROWS[i].sel_ab, ROWS[i].sel_ba);
      set_ext(ROWS[i].a_ext, ROWS[i].a_in, ROWS[i].b_ext, ROWS[i].b_in);
      #1;
      check($sformatf("R4 R5 R6 row %0d a_oe", i), a_oe_o, {W{ROWS[i].a_oe}});
      check($sformatf("R4 R5 R6 row %0d b_oe", i), b_oe_o, {W{ROWS[i].b_oe}});
      if (ROWS[i].a_oe)
        check($sformatf("R8 R9 R11 row %0d a_out", i), a_out_o, ROWS[i].a_out);
      if (ROWS[i].b_oe)
        check($sformatf("R7 R9 R11 row %0d b_out", i), b_out_o, ROWS[i].b_out);
    end

    // R2: capture with both sides driven by the block in exchange mode
    step();
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    set_ext(1'b1, 8'hE1, 1'b0, '0);
    pulse_a();
    check("R2 capture in exchange mode", b_out_o, 8'hE1);
    // R2: capture with both enables off
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    set_ext(1'b0, '0, 1'b1, 8'h7E);
    pulse_b();
    set_ext(1'b0, '0, 1'b0, '0);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    check("R2 capture while isolated", a_out_o, 8'h7E);

    // R10: live A onto B, then B clock stores the A value
    step();
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    set_ext(1'b1, 8'h4D, 1'b0, '0);
    pulse_b();
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    set_ext(1'b0, '0, 1'b0, '0);
    #1;
    check("R10 A value in B register", a_out_o, 8'h4D);
    // R10 mirror: live B onto A, A clock stores the B value
    step();
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    set_ext(1'b0, '0, 1'b1, 8'hB2);
    pulse_a();
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    set_ext(1'b0, '0, 1'b0, '0);
    #1;
    check("R10 B value in A register", b_out_o, 8'hB2);

    // R3: keeper on an undriven bus feeds a live path
    step();
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    set_ext(1'b1, 8'h3A, 1'b0, '0);
    step();
    step();
    set_ext(1'b0, '0, 1'b0, '0);
    step();
    step();
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    #1;
    check("R3 keeper value on live path", b_out_o, 8'h3A);

    // R12: joined bus keeps the last value after A driver releases
    step();
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    set_ext(1'b1, 8'h5E, 1'b0, '0);
    step();
    step();
    set_ext(1'b0, '0, 1'b0, '0);
    repeat (5) step();
    #1;
    check("R12 A held after release", a_out_o, 8'h5E);
    check("R12 B held after release", b_out_o, 8'h5E);
    pulse_b();
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    check("R12 kept value captured", a_out_o, 8'h5E);

    // R12: joined bus keeps the last value after B driver releases
    step();
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    set_ext(1'b0, '0, 1'b1, 8'h21);
    step();
    step();
    set_ext(1'b0, '0, 1'b0, '0);
    repeat (6) step();
    #1;
    check("R12 A held after B release", a_out_o, 8'h21);
    check("R12 B held after B release", b_out_o, 8'h21);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule